// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register Block

This block holds the software-visible registers of a two-channel bus-master disk DMA controller. It occupies a 16-byte I/O window. Address bit 3 selects the channel, so channel n starts at byte n×8. Each channel has a command byte, a status byte and a 32-bit descriptor-table pointer. The command byte and the pointer go straight out to the DMA engine. The engine in turn reports its running state and sends one-cycle pulses that set the error and interrupt flags in status.

Accesses arrive on a request interface with a valid strobe, a write flag, an address, a size code and write data. The block never applies back-pressure: it takes a request in every cycle that the valid strobe is high. A read answers exactly one cycle later on a response strobe with data. The response has no ready signal, so the requester must take it in the cycle it appears.

On the engine side, each channel of the design is tied to a fixed legacy drive port pair and interrupt line: channel 0 to 0x1F0/0x3F6 and line 14, channel 1 to 0x170/0x376 and line 15. That wiring sits outside this block.

Top module: `bmdma_regs`

## Requirements
- R1: Reset clears, on both channels, the command byte, the pointer and the stored status bits (1, 2, 5, 6), and drops the response strobe.
- R2: Address bit 3 picks the channel. Within a channel, byte offset 0 is the command register, offset 2 is status, and offsets 4 to 7 are the pointer. A one-byte write to offset 0 appears on the channel's command output.
- R3: A one-byte read of offset 1 or offset 3 of a channel returns 0xFF.
- R4: A read of offsets 0 to 3 whose size code is not 0 (one byte) returns all ones across the access width. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R5: A write of offsets 0 to 3 whose size code is not 0 changes neither command nor status.
- R6: A one-byte status write loads status bits 5 and 6 from the written data. Status bits 3, 4 and 7 always read as zero.
- R7: Status bit 0 shows the engine's active input for that channel, and software writes cannot change it.
- R8: On a status write, bits 1 (error) and 2 (interrupt) clear wherever the written byte has a 1 and hold wherever it has a 0.
- R9: An engine error pulse sets status bit 1, and an engine interrupt pulse sets bit 2. When a pulse and a software clear of the same bit fall in one cycle, the bit ends up set.
- R10: A 4-byte write anywhere in offsets 4 to 7 loads the whole pointer. A one-byte write loads the pointer byte at (offset − 4). A 2-byte write to the pointer is ignored. Pointer bits 1:0 always read as zero.
- R11: A read of offsets 4 to 7 returns the pointer shifted right by 8×(offset − 4), masked to the access width.
- R12: A read request raises the response strobe with its data on the next clock cycle. Write requests and idle cycles produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte address inside the window |
| acc_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| acc_wdata | input | 32 | Write data, low-aligned |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read data, zero above the access width |
| eng_active | input | 2 | Engine running flag, one bit per channel |
| eng_err_set | input | 2 | Engine error pulse, one bit per channel |
| eng_irq_set | input | 2 | Engine interrupt pulse, one bit per channel |
| cmd_out | output | 16 | Command byte of each channel, channel 0 in the low byte |
| desc_ptr_out | output | 64 | Descriptor pointer of each channel, channel 0 in the low word |

## Verification
The hardest case to reach from the ports is an engine pulse landing in the same cycle as a software write that clears the same status bit. Random stimulus rarely lines these up. A directed sequence therefore drives the clear write and the pulse on the same edge, and a read on the next cycle shows which one won. Random traffic also draws sizes and offsets independently. This brings about wide accesses to the command and status bytes, byte writes into every pointer lane, and 2-byte pointer writes, and a reference model checks each read against the result it expects.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int SLICE_BYTES = 8;
  localparam int DESC_W      = 32;
  localparam int BUS_W       = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD3 = 2'd3
  } acc_size_e;

  function automatic logic [BUS_W-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: width_mask = 32'h0000_00FF;
      SZ_HALF: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode #(
  parameter int NCH    = 2,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int ADDR_W = 3 + CH_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [CH_W-1:0]   ch,
  output logic              ch_ok,
  output logic              in_ptr,
  output logic              is_byte,
  output logic              is_cmd,
  output logic              is_sts,
  output logic [1:0]        lane
);
  import bmdma_pkg::*;

  always_comb begin
    ch      = addr[ADDR_W-1:3];
    ch_ok   = (32'(ch) < NCH);
    in_ptr  = addr[2];
    lane    = addr[1:0];
    is_byte = (size == SZ_BYTE);
    is_cmd  = !addr[2] && (addr[1:0] == 2'd0);
    is_sts  = !addr[2] && (addr[1:0] == 2'd2);
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              sts_we,
  input  logic              ptr_we_all,
  input  logic              ptr_we_byte,
  input  logic [1:0]        lane,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              hw_active,
  input  logic              err_set,
  input  logic              irq_set,
  output logic [7:0]        cmd,
  output logic [7:0]        sts,
  output logic [DESC_W-1:0] ptr
);
  logic       err_q, irq_q;
  logic [1:0] cap_q;
  logic [DESC_W-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr;
    if (ptr_we_all)       ptr_nxt = wdata[DESC_W-1:0];
    else if (ptr_we_byte) ptr_nxt[8*lane +: 8] = wdata[7:0];
    ptr_nxt[1:0] = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd   <= '0;
      ptr   <= '0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      cap_q <= '0;
    end else begin
      if (cmd_we) cmd <= wdata[7:0];
      if (ptr_we_all || ptr_we_byte) ptr <= ptr_nxt;
      if (sts_we) cap_q <= wdata[6:5];
      err_q <= err_set | (err_q & ~(sts_we & wdata[1]));
      irq_q <= irq_set | (irq_q & ~(sts_we & wdata[2]));
    end
  end

  assign sts = {1'b0, cap_q, 2'b00, irq_q, err_q, hw_active};

  // R9
  err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> sts[1]);
  // R9
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> sts[2]);
  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && wdata[1] && !err_set) |=> !sts[1]);
  // R6
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |=> (sts[6:5] == $past(wdata[6:5])));
  // R10
  ptr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we_all |=> (ptr[DESC_W-1:2] == $past(wdata[DESC_W-1:2])));
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = 3 + CH_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [1:0]            acc_size,
  input  logic [BUS_W-1:0]      acc_wdata,
  output logic                  rsp_valid,
  output logic [BUS_W-1:0]      rsp_data,
  input  logic [NCH-1:0]        eng_active,
  input  logic [NCH-1:0]        eng_err_set,
  input  logic [NCH-1:0]        eng_irq_set,
  output logic [NCH*8-1:0]      cmd_out,
  output logic [NCH*DESC_W-1:0] desc_ptr_out
);
  logic [CH_W-1:0] d_ch;
  logic            d_ch_ok, d_in_ptr, d_byte, d_cmd, d_sts;
  logic [1:0]      d_lane;
  logic            wr_go;

  logic [7:0]        ch_cmd [NCH];
  logic [7:0]        ch_sts [NCH];
  logic [DESC_W-1:0] ch_ptr [NCH];

  bmdma_decode #(.NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .addr(acc_addr), .size(acc_size), .ch(d_ch), .ch_ok(d_ch_ok),
    .in_ptr(d_in_ptr), .is_byte(d_byte), .is_cmd(d_cmd), .is_sts(d_sts),
    .lane(d_lane)
  );

  assign wr_go = acc_valid && acc_write && d_ch_ok;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = wr_go && (d_ch == CH_W'(g));
    bmdma_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(hit && d_byte && d_cmd),
      .sts_we(hit && d_byte && d_sts),
      .ptr_we_all(hit && d_in_ptr && acc_size[1]),
      .ptr_we_byte(hit && d_in_ptr && d_byte),
      .lane(d_lane), .wdata(acc_wdata),
      .hw_active(eng_active[g]),
      .err_set(eng_err_set[g]), .irq_set(eng_irq_set[g]),
      .cmd(ch_cmd[g]), .sts(ch_sts[g]), .ptr(ch_ptr[g])
    );
    assign cmd_out[8*g +: 8]                = ch_cmd[g];
    assign desc_ptr_out[DESC_W*g +: DESC_W] = ch_ptr[g];
  end

  logic [BUS_W-1:0] rd_raw;
  always_comb begin
    rd_raw = '0;
    if (d_ch_ok) begin
      if (d_in_ptr)      rd_raw = ch_ptr[d_ch] >> (8 * d_lane);
      else if (!d_byte)  rd_raw = '1;
      else if (d_cmd)    rd_raw = {24'h0, ch_cmd[d_ch]};
      else if (d_sts)    rd_raw = {24'h0, ch_sts[d_ch]};
      else               rd_raw = 32'h0000_00FF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rsp_data <= rd_raw & width_mask(acc_size);
    end
  end

  // R12
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rsp_valid);
  // R12
  no_rsp_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rsp_valid);
  // R5
  wide_ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !d_in_ptr && !d_byte) |=> $stable(cmd_out));
  // R4
  wide_ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !d_in_ptr && (acc_size == SZ_HALF))
      |=> (rsp_data == 32'h0000_FFFF));
endmodule

// File: tb/test_bmdma_regs.sv
`timescale 1ns/1ps
module test_bmdma_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [1:0]  eng_active = '0, eng_err_set = '0, eng_irq_set = '0;
  logic [15:0] cmd_out;
  logic [63:0] desc_ptr_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0]  m_cmd [2];
  logic [31:0] m_ptr [2];
  logic        m_err [2], m_irq [2];
  logic [1:0]  m_cap [2];

  always #5 clk = ~clk;

  bmdma_regs i_bmdma_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .eng_active(eng_active),
    .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set),
    .cmd_out(cmd_out), .desc_ptr_out(desc_ptr_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] sz);
    int c = a[3];
    logic [31:0] raw;
    if (a[2])             raw = m_ptr[c] >> (8 * a[1:0]);
    else if (sz != 2'd0)  raw = 32'hFFFF_FFFF;
    else if (a[1:0] == 0) raw = {24'h0, m_cmd[c]};
    else if (a[1:0] == 2) raw = {24'h0, 1'b0, m_cap[c], 2'b00, m_irq[c], m_err[c], eng_active[c]};
    else                  raw = 32'hFF;
    return raw & mask_of(sz);
  endfunction

  function automatic string tag_of(input logic [3:0] a, input logic [1:0] sz);
    if (a[2])             return "R11";
    if (sz != 2'd0)       return "R4";
    if (a[1:0] == 0)      return "R2";
    if (a[1:0] == 2)      return "R8";
    return "R3";
  endfunction

  task automatic model_update(input logic v, input logic w, input logic [3:0] a,
                              input logic [1:0] sz, input logic [31:0] d);
    for (int c = 0; c < 2; c++) begin
      logic hit = v && w && (a[3] == c[0]);
      logic sw  = hit && !a[2] && a[1:0] == 2 && sz == 0;
      if (hit && !a[2] && a[1:0] == 0 && sz == 0) m_cmd[c] = d[7:0];
      if (sw) m_cap[c] = d[6:5];
      m_err[c] = eng_err_set[c] | (m_err[c] & ~(sw & d[1]));
      m_irq[c] = eng_irq_set[c] | (m_irq[c] & ~(sw & d[2]));
      if (hit && a[2] && sz[1]) m_ptr[c] = d & 32'hFFFF_FFFC;
      else if (hit && a[2] && sz == 0) begin
        m_ptr[c][8*a[1:0] +: 8] = d[7:0];
        m_ptr[c][1:0] = 2'b00;
      end
    end
  endtask

  task automatic op(input logic w, input logic [3:0] a, input logic [1:0] sz,
                    input logic [31:0] d, input logic [1:0] es, input logic [1:0] is,
                    input string req);
    logic [31:0] e;
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_size = sz; acc_wdata = d;
    eng_err_set = es; eng_irq_set = is;
    e = exp_read(a, sz);
    @(posedge clk); #1;
    model_update(1'b1, w, a, sz, d);
    acc_valid = 1'b0; eng_err_set = '0; eng_irq_set = '0;
    @(negedge clk);
    check("R12", {63'h0, rsp_valid}, {63'h0, !w});
    if (!w) check(req, {32'h0, rsp_data}, {32'h0, e});
    check(req, {48'h0, cmd_out}, {48'h0, m_cmd[1], m_cmd[0]});
    check(req, desc_ptr_out, {m_ptr[1], m_ptr[0]});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = '0; m_ptr[c] = '0; m_err[c] = 0; m_irq[c] = 0; m_cap[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state through the ports
    check("R1", {63'h0, rsp_valid}, 64'h0);
    check("R1", {48'h0, cmd_out}, 64'h0);
    check("R1", desc_ptr_out, 64'h0);
    op(0, 4'h2, 0, 0, 0, 0, "R1");
    op(0, 4'hA, 0, 0, 0, 0, "R1");
    // R2 command byte and channel select
    op(1, 4'h0, 0, 32'hA5, 0, 0, "R2");
    op(1, 4'h8, 0, 32'h3C, 0, 0, "R2");
    op(0, 4'h8, 0, 0, 0, 0, "R2");
    // R3 pad bytes
    op(0, 4'h1, 0, 0, 0, 0, "R3");
    op(0, 4'hB, 0, 0, 0, 0, "R3");
    // R4 wide reads of control sub-window
    op(0, 4'h0, 1, 0, 0, 0, "R4");
    op(0, 4'hA, 2, 0, 0, 0, "R4");
    // R5 wide writes ignored
    op(1, 4'h0, 2, 32'hFFFF_FFFF, 0, 0, "R5");
    op(1, 4'h2, 1, 32'h0066, 0, 0, "R5");
    op(0, 4'h2, 0, 0, 0, 0, "R5");
    // R6 capability bits, reserved bits zero
    op(1, 4'h2, 0, 32'hFF, 0, 0, "R6");
    op(0, 4'h2, 0, 0, 0, 0, "R6");
    // R7 active bit follows engine, write cannot change it
    eng_active = 2'b10;
    op(1, 4'hA, 0, 32'h01, 0, 0, "R7");
    op(0, 4'hA, 0, 0, 0, 0, "R7");
    op(0, 4'h2, 0, 0, 0, 0, "R7");
    // R9 pulses set bits; R8 write-one-to-clear
    op(0, 4'h2, 0, 0, 2'b01, 2'b01, "R9");
    op(0, 4'h2, 0, 0, 0, 0, "R9");
    op(1, 4'h2, 0, 32'h02, 0, 0, "R8");
    op(0, 4'h2, 0, 0, 0, 0, "R8");
    // R9 set wins over same-cycle clear
    op(1, 4'h2, 0, 32'h06, 2'b01, 2'b00, "R9");
    op(0, 4'h2, 0, 0, 0, 0, "R9");
    // R10 pointer writes
    op(1, 4'h4, 2, 32'h1234_5677, 0, 0, "R10");
    op(1, 4'hD, 0, 32'h0000_00EE, 0, 0, "R10");
    op(1, 4'hC, 0, 32'h0000_00FF, 0, 0, "R10");
    op(1, 4'h6, 1, 32'h0000_BEEF, 0, 0, "R10");
    op(0, 4'hC, 2, 0, 0, 0, "R10");
    // R11 pointer reads at offsets
    op(0, 4'h5, 0, 0, 0, 0, "R11");
    op(0, 4'h6, 1, 0, 0, 0, "R11");
    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] a = 4'($urandom);
      logic [1:0] sz = 2'($urandom);
      logic w = 1'($urandom);
      logic [1:0] es = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      logic [1:0] is = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      if ($urandom % 2 == 0) sz = 2'd0;
      eng_active = 2'($urandom);
      op(w, a, sz, $urandom, es, is, tag_of(a, sz));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule